// File: doc/BRIEF.md
# Gray-Coded Control Bus Crossing

This block moves a narrow control bus from a source clock into an unrelated destination clock. The bus is captured in a source-side register. Each bit of that register then passes through its own chain of flip-flops clocked by the destination clock. No common enable and no handshake are involved. This only works if every change of the registered value flips at most one bit. When that holds, the destination sees either the previous code or the new one, and never a mix of the two.

Two checkers guard that rule at runtime. On the source side, a flag goes high for one source cycle after any load that would flip two or more bits at once. The load still takes effect, and the flag only reports it. On the destination side, every synchronized value is looked up in a parameter mask that lists the legal codes. Any code missing from the mask raises a flag. A transient value caused by a badly coded source shows up on this flag.

Top module: `gcb_cross`

## Requirements
- R1: A value loaded into the source register appears on `dst_code` no later than SYNC_STAGES+1 destination cycles after the source edge that loaded it, given one or more destination cycles between loads.
- R2: The source register takes `src_data` on a `src_clk` edge where `src_load` is 1, and keeps its value on every other edge.
- R3: After a load whose `src_data` differs from the registered value in two or more bits, `err_multi_bit` is 1 during the next source cycle.
- R4: `err_multi_bit` is 0 in any source cycle that does not follow such a load. This covers cycles after single-bit loads, cycles after loads of the unchanged value, and idle cycles.
- R5: Bit k of LEGAL_MASK (default 4'b1011) marks code k as legal. `err_illegal_code` is 1 in the destination cycle after one in which `dst_code` held an illegal code, and is 0 otherwise. With the defaults, code 2'b10 is the only illegal code.
- R6: While the resets are held, the source register and every synchronizer stage take RESET_VAL (default 0) and both flags are 0. A load attempted during reset leaves no trace after the resets are released.
- R7: A sequence of single-bit updates reaches `dst_code` in the same order, with no value added or skipped.
- R8: A multi-bit update is flagged but not blocked. Its value still reaches `dst_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| src_rst | input | 1 | Source synchronous reset, active high |
| src_load | input | 1 | Load strobe for the source register |
| src_data | input | WIDTH | New control code |
| err_multi_bit | output | 1 | Source update flipped more than one bit |
| dst_clk | input | 1 | Destination clock |
| dst_rst | input | 1 | Destination synchronous reset, active high |
| dst_code | output | WIDTH | Synchronized control code |
| err_illegal_code | output | 1 | Previous destination code was outside the legal set |

## Verification
The source flag is registered on the edge that performs the load, so the bench samples it at the next source falling edge and again one cycle later to confirm that it has cleared. Destination values arrive two or three destination edges after the load. For that reason the scoreboard does not compare at a fixed cycle: it pops one expected code each time `dst_code` changes. It then confirms that the queue is empty five destination cycles after each load, which enforces the bound in R1. The illegal-code flag lags `dst_code` by exactly one destination edge, so at each destination falling edge the monitor compares it against the legality of the code it saw one falling edge earlier.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

    // widest bus the helpers below accept
    localparam int GCB_MAX_W = 16;

    // number of set bits in a vector
    function automatic int unsigned gcb_popcount(input logic [GCB_MAX_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < GCB_MAX_W; i++) begin
            n = n + {31'd0, v[i]};
        end
        return n;
    endfunction

    // true when the two codes are more than one bit apart
    function automatic logic gcb_multi_flip(input logic [GCB_MAX_W-1:0] a,
                                            input logic [GCB_MAX_W-1:0] b);
        return gcb_popcount(a ^ b) > 1;
    endfunction

endpackage

// File: rtl/gcb_src_reg.sv
module gcb_src_reg
    import gcb_pkg::*;
#(
    parameter int              WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] q,
    output logic             err
);

    logic [GCB_MAX_W-1:0] new_ext;
    logic [GCB_MAX_W-1:0] cur_ext;
    logic                 bad_step;

    assign new_ext  = GCB_MAX_W'(data);
    assign cur_ext  = GCB_MAX_W'(q);
    assign bad_step = load && gcb_multi_flip(new_ext, cur_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= RESET_VAL;
            err <= 1'b0;
        end else begin
            err <= bad_step;
            if (load) begin
                q <= data;
            end
        end
    end

endmodule

// File: rtl/gcb_bit_sync.sv
module gcb_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES >= 2) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_BIT}};
                end else begin
                    chain <= {chain[STAGES-2:0], d};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_BIT}};
                end else begin
                    chain <= d;
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gcb_code_chk.sv
module gcb_code_chk #(
    parameter int                     WIDTH      = 2,
    parameter logic [(1<<WIDTH)-1:0]  LEGAL_MASK = 4'b1011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] code,
    output logic             err
);

    logic code_ok;

    assign code_ok = LEGAL_MASK[code];

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else begin
            err <= !code_ok;
        end
    end

endmodule

// File: rtl/gcb_cross.sv
module gcb_cross #(
    parameter int                    WIDTH       = 2,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0]      RESET_VAL   = '0,
    parameter logic [(1<<WIDTH)-1:0] LEGAL_MASK  = 4'b1011
) (
    input  logic             src_clk,
    input  logic             src_rst,
    input  logic             src_load,
    input  logic [WIDTH-1:0] src_data,
    output logic             err_multi_bit,
    input  logic             dst_clk,
    input  logic             dst_rst,
    output logic [WIDTH-1:0] dst_code,
    output logic             err_illegal_code
);

    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] sync_q;

    gcb_src_reg #(
        .WIDTH     (WIDTH),
        .RESET_VAL (RESET_VAL)
    ) u_src (
        .clk  (src_clk),
        .rst  (src_rst),
        .load (src_load),
        .data (src_data),
        .q    (src_q),
        .err  (err_multi_bit)
    );

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            gcb_bit_sync #(
                .STAGES  (SYNC_STAGES),
                .RST_BIT (RESET_VAL[b])
            ) u_sync (
                .clk (dst_clk),
                .rst (dst_rst),
                .d   (src_q[b]),
                .q   (sync_q[b])
            );
        end
    endgenerate

    assign dst_code = sync_q;

    gcb_code_chk #(
        .WIDTH      (WIDTH),
        .LEGAL_MASK (LEGAL_MASK)
    ) u_chk (
        .clk  (dst_clk),
        .rst  (dst_rst),
        .code (sync_q),
        .err  (err_illegal_code)
    );

endmodule

// File: rtl/gcb_cross_chk.sv
module gcb_cross_chk
    import gcb_pkg::*;
#(
    parameter int                    WIDTH      = 2,
    parameter logic [WIDTH-1:0]      RESET_VAL  = '0,
    parameter logic [(1<<WIDTH)-1:0] LEGAL_MASK = 4'b1011
) (
    input logic             src_clk,
    input logic             src_rst,
    input logic             src_load,
    input logic [WIDTH-1:0] src_data,
    input logic [WIDTH-1:0] src_q,
    input logic             err_multi_bit,
    input logic             dst_clk,
    input logic             dst_rst,
    input logic [WIDTH-1:0] dst_code,
    input logic             err_illegal_code
);

    // R2
    load_take_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        src_load |=> (src_q == $past(src_data)));

    // R2
    idle_hold_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        (!$past(src_load) && !$past(src_rst)) |-> $stable(src_q));

    // R3
    multi_flag_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        (src_load && gcb_multi_flip(GCB_MAX_W'(src_data), GCB_MAX_W'(src_q))) |=> err_multi_bit);

    // R4
    flag_cause_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        err_multi_bit |-> ($past(src_load) && !$past(src_rst)));

    // R5
    illegal_raise_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (!$past(dst_rst) && !LEGAL_MASK[$past(dst_code)]) |-> err_illegal_code);

    // R5
    illegal_cause_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        err_illegal_code |-> !LEGAL_MASK[$past(dst_code)]);

    // R6
    src_reset_chk: assert property (@(posedge src_clk) disable iff (src_rst)
        $past(src_rst) |-> (src_q == RESET_VAL && !err_multi_bit));

    // R6
    dst_reset_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $past(dst_rst) |-> (dst_code == RESET_VAL && !err_illegal_code));

endmodule

bind gcb_cross gcb_cross_chk #(
    .WIDTH      (WIDTH),
    .RESET_VAL  (RESET_VAL),
    .LEGAL_MASK (LEGAL_MASK)
) u_cross_chk (
    .src_clk          (src_clk),
    .src_rst          (src_rst),
    .src_load         (src_load),
    .src_data         (src_data),
    .src_q            (src_q),
    .err_multi_bit    (err_multi_bit),
    .dst_clk          (dst_clk),
    .dst_rst          (dst_rst),
    .dst_code         (dst_code),
    .err_illegal_code (err_illegal_code)
);

// File: tb/tb_gcb_cross.sv
module tb_gcb_cross;

    localparam int          SRC_PERIOD = 10;
    localparam int          DST_PERIOD = 14;
    localparam int          W          = 2;
    localparam logic [3:0]  LEGAL      = 4'b1011;
    localparam logic [W-1:0] RST_CODE  = 2'b00;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst = 1'b1;
    logic         dst_rst = 1'b1;
    logic         src_load = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         err_multi_bit;
    logic [W-1:0] dst_code;
    logic         err_illegal_code;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] expq[$];
    logic [W-1:0] model = RST_CODE;
    logic [W-1:0] last_seen = RST_CODE;
    logic         prev_bad = 1'b0;
    bit           done = 1'b0;

    always #(SRC_PERIOD/2) src_clk = ~src_clk;
    always #(DST_PERIOD/2) dst_clk = ~dst_clk;

    gcb_cross dut (
        .src_clk          (src_clk),
        .src_rst          (src_rst),
        .src_load         (src_load),
        .src_data         (src_data),
        .err_multi_bit    (err_multi_bit),
        .dst_clk          (dst_clk),
        .dst_rst          (dst_rst),
        .dst_code         (dst_code),
        .err_illegal_code (err_illegal_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // monitor: scoreboard of destination codes and the illegal-code flag
    always @(negedge dst_clk) begin
        if (dst_rst) begin
            last_seen = RST_CODE;
            prev_bad  = 1'b0;
        end else begin
            // R5: flag reflects legality of the code one edge earlier
            check(err_illegal_code == prev_bad, "R5", int'(err_illegal_code), int'(prev_bad));
            if (dst_code != last_seen) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected code", int'(dst_code), -1);
                end else begin
                    logic [W-1:0] e;
                    e = expq.pop_front();
                    check(dst_code == e, "R7", int'(dst_code), int'(e));
                end
                last_seen = dst_code;
            end
            prev_bad = !LEGAL[dst_code];
        end
    end

    // driver: one load, flag checks, then delivery window
    task automatic drive(input logic [W-1:0] code, input string req);
        logic exp_err;
        exp_err = $countones(code ^ model) > 1;
        @(negedge src_clk);
        src_load = 1'b1;
        src_data = code;
        if (code != model) expq.push_back(code);
        model = code;
        @(negedge src_clk);
        src_load = 1'b0;
        // R3 / R4
        check(err_multi_bit == exp_err, exp_err ? "R3" : "R4", int'(err_multi_bit), int'(exp_err));
        @(negedge src_clk);
        check(err_multi_bit == 1'b0, "R4 pulse", int'(err_multi_bit), 0);
        repeat (5) @(negedge dst_clk);
        // R1: delivered within the window
        check(expq.size() == 0, {"R1 ", req}, expq.size(), 0);
        check(dst_code == model, {"R1 ", req}, int'(dst_code), int'(model));
    endtask

    initial begin
        #(SRC_PERIOD * 20000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge dst_clk);
        // R6: reset state
        check(dst_code == RST_CODE, "R6", int'(dst_code), int'(RST_CODE));
        check(err_multi_bit == 1'b0, "R6", int'(err_multi_bit), 0);
        check(err_illegal_code == 1'b0, "R6", int'(err_illegal_code), 0);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        repeat (3) @(negedge dst_clk);

        drive(2'b01, "R7 step");
        drive(2'b11, "R7 step");
        drive(2'b10, "R5 illegal");
        drive(2'b11, "R7 step");
        drive(2'b01, "R7 step");
        drive(2'b00, "R7 step");
        drive(2'b11, "R8 multi");
        drive(2'b11, "R4 same");
        drive(2'b00, "R8 multi");
        drive(2'b10, "R5 illegal");
        drive(2'b01, "R8 multi");

        // R4: idle cycles keep the flag low
        repeat (4) begin
            @(negedge src_clk);
            check(err_multi_bit == 1'b0, "R4 idle", int'(err_multi_bit), 0);
        end
        // R2: idle source keeps the delivered code
        check(dst_code == 2'b01, "R2 hold", int'(dst_code), 1);

        // R6: load during reset is ignored
        @(negedge dst_clk);
        src_rst  = 1'b1;
        dst_rst  = 1'b1;
        src_load = 1'b1;
        src_data = 2'b11;
        repeat (4) @(negedge dst_clk);
        check(dst_code == RST_CODE, "R6 in reset", int'(dst_code), int'(RST_CODE));
        check(err_multi_bit == 1'b0, "R6 in reset", int'(err_multi_bit), 0);
        src_load = 1'b0;
        expq.delete();
        model = RST_CODE;
        @(negedge dst_clk);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        repeat (6) @(negedge dst_clk);
        check(dst_code == RST_CODE, "R6 after reset", int'(dst_code), int'(RST_CODE));
        check(err_illegal_code == 1'b0, "R6 after reset", int'(err_illegal_code), 0);
        check(err_multi_bit == 1'b0, "R6 after reset", int'(err_multi_bit), 0);
        drive(2'b01, "R6 resume");

        finish_run();
    end

endmodule